// File: doc/BRIEF.md
# Bus Clock Start-Up and Low-Power Sequencer

This block turns a fast oscillator clock into the gated clock enables of a small 8-bit microcontroller. The bus runs at one quarter of the oscillator rate: a two-bit phase counter produces a single-cycle bus pulse every fourth oscillator cycle. The CPU enable and the peripheral enable are copies of that pulse, each gated by the current power state. Downstream logic runs on the oscillator clock and qualifies its flops with these enables.

The block holds the bus idle while a shared start-up counter runs. This happens after power-on and after an external reset, with the reset pin held low for the whole count. It also happens after a wake from stop mode. The stop-recovery count is either long or short, chosen by a select bit that is captured when stop is entered. In wait mode the CPU enable is withheld, while the peripheral enable and the bus phase keep running. A wake event brings the CPU back at the next bus-cycle boundary.

Top module: `busclk_sequencer`

## Requirements
- R1: While the bus runs, `bus_phase_o` is high for exactly one oscillator cycle in every four. The bus always starts at phase zero, so the first pulse comes in the first running cycle. `cpu_en_o` and `periph_en_o` are high only in cycles where `bus_phase_o` is high.
- R2: After `por_i` is released, `rst_pin_n_o` stays low and all enables stay low for 4096 oscillator cycles. In the cycle after the 4096th rising edge, `rst_pin_n_o` goes high and `bus_phase_o`, `cpu_en_o` and `periph_en_o` pulse.
- R3: No enable is ever high while `rst_pin_n_o` is low.
- R4: A stop request is taken at the rising edge that ends phase 3 of a bus cycle. From then on all enables stay low until a wake event. A wake event is `wake_irq_i` or `wake_brk_i`. With `short_dly_i` low at entry, the first enables appear 4096 cycles after the edge that sampled the wake.
- R5: With `short_dly_i` high at stop entry, the first enables appear 32 cycles after the edge that sampled the wake.
- R6: `short_dly_i` is sampled only at stop entry. Changing it during stop or during the recovery count does not change the recovery length.
- R7: A wait request (with no stop request) is taken at the edge that ends phase 3. In wait mode, `bus_phase_o` and `periph_en_o` keep pulsing every four cycles and `cpu_en_o` stays low.
- R8: A wake pulse in wait mode, in any phase, returns `cpu_en_o` at the next bus-cycle boundary with no time-out.
- R9: `ext_rst_i` in any state drives `rst_pin_n_o` low in the next cycle and restarts the full 4096-cycle count. This also applies during a stop-recovery count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Fast oscillator clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| stop_req_i | input | 1 | Request to enter stop mode |
| wait_req_i | input | 1 | Request to enter wait mode |
| wake_irq_i | input | 1 | Interrupt wake event |
| wake_brk_i | input | 1 | Break wake event |
| ext_rst_i | input | 1 | External reset, restarts the power-on sequence |
| short_dly_i | input | 1 | Stop-recovery select: 1 = 32 cycles, 0 = 4096 cycles |
| bus_phase_o | output | 1 | One-cycle bus phase pulse |
| cpu_en_o | output | 1 | CPU clock enable pulse |
| periph_en_o | output | 1 | Peripheral clock enable pulse |
| rst_pin_n_o | output | 1 | Reset pin drive, active low |

## Verification
All outputs are decoded from registered state, so every result is due in the cycle after the edge that samples its cause. A stop or wait request takes four edges from a phase-zero pulse. A stop wake shows enables after exactly 4096 or 32 further edges. A wait wake shows `cpu_en_o` at the edge that ends the current phase 3. The bench counts edges from a known phase-zero pulse and samples 2 ns after each edge. It checks both the last quiet cycle and the first active one, so a delay that is off by one is reported.

// File: rtl/busclk_seq_pkg.sv
package busclk_seq_pkg;
    typedef enum logic [2:0] {
        ST_PWRUP   = 3'd0,
        ST_RUN     = 3'd1,
        ST_WAIT    = 3'd2,
        ST_STOP    = 3'd3,
        ST_RECOVER = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       short_sel;
        logic       wake_pend;
    } seq_regs_t;
endpackage

// File: rtl/busclk_phase_ctr.sv
module busclk_phase_ctr #(
    parameter int DIV = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   run_i,
    output logic [$clog2(DIV)-1:0] phase_o,
    output logic                   last_o
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = '0;
        if (run_i && ph_q != LAST) ph_d = ph_q + 1'b1;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) ph_q <= '0;
        else       ph_q <= ph_d;
    end

    assign phase_o = ph_q;
    assign last_o  = (ph_q == LAST);
endmodule

// File: rtl/busclk_wake_timer.sv
module busclk_wake_timer #(
    parameter int LONG_CYC  = 4096,
    parameter int SHORT_CYC = 32
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic count_i,
    input  logic short_i,
    output logic done_o
);
    localparam int CW = $clog2(LONG_CYC) + 1;
    localparam logic [CW-1:0] LONG_END  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_END = CW'(SHORT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (count_i && !clr_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign done_o = count_i && (cnt_q == (short_i ? SHORT_END : LONG_END));
endmodule

// File: rtl/busclk_sequencer.sv
module busclk_sequencer
    import busclk_seq_pkg::*;
#(
    parameter int LONG_CYC  = 4096,
    parameter int SHORT_CYC = 32,
    parameter int BUS_DIV   = 4
) (
    input  logic osc_clk_i,
    input  logic por_i,
    input  logic stop_req_i,
    input  logic wait_req_i,
    input  logic wake_irq_i,
    input  logic wake_brk_i,
    input  logic ext_rst_i,
    input  logic short_dly_i,
    output logic bus_phase_o,
    output logic cpu_en_o,
    output logic periph_en_o,
    output logic rst_pin_n_o
);
    localparam int PW = $clog2(BUS_DIV);

    seq_regs_t r_d, r_q;
    logic [PW-1:0] phase;
    logic phase_last, timer_done, running, counting, wake;

    assign running  = (r_q.st == ST_RUN) || (r_q.st == ST_WAIT);
    assign counting = (r_q.st == ST_PWRUP) || (r_q.st == ST_RECOVER);
    assign wake     = wake_irq_i || wake_brk_i;

    busclk_phase_ctr #(.DIV(BUS_DIV)) u_phase (
        .clk_i   (osc_clk_i),
        .rst_i   (por_i),
        .run_i   (running),
        .phase_o (phase),
        .last_o  (phase_last)
    );

    busclk_wake_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
        .clk_i   (osc_clk_i),
        .rst_i   (por_i),
        .clr_i   (ext_rst_i),
        .count_i (counting),
        .short_i ((r_q.st == ST_RECOVER) && r_q.short_sel),
        .done_o  (timer_done)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_PWRUP: if (timer_done) r_d.st = ST_RUN;
            ST_RUN: begin
                if (phase_last) begin
                    if (stop_req_i) begin
                        r_d.st        = ST_STOP;
                        r_d.short_sel = short_dly_i;
                    end else if (wait_req_i) begin
                        r_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (wake) r_d.wake_pend = 1'b1;
                if (phase_last && (wake || r_q.wake_pend)) begin
                    r_d.st        = ST_RUN;
                    r_d.wake_pend = 1'b0;
                end
            end
            ST_STOP:    if (wake) r_d.st = ST_RECOVER;
            ST_RECOVER: if (timer_done) r_d.st = ST_RUN;
            default:    r_d.st = ST_PWRUP;
        endcase
        if (ext_rst_i) begin
            r_d.st        = ST_PWRUP;
            r_d.wake_pend = 1'b0;
        end
    end

    always_ff @(posedge osc_clk_i or posedge por_i) begin
        if (por_i) begin
            r_q.st        <= ST_PWRUP;
            r_q.short_sel <= 1'b0;
            r_q.wake_pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_phase_o = running && (phase == '0);
    assign cpu_en_o    = bus_phase_o && (r_q.st == ST_RUN);
    assign periph_en_o = bus_phase_o;
    assign rst_pin_n_o = (r_q.st != ST_PWRUP);
endmodule

// File: rtl/busclk_seq_chk.sv
module busclk_seq_chk
    import busclk_seq_pkg::*;
(
    input logic       clk_i,
    input logic       por_i,
    input logic       ext_rst_i,
    input logic       bus_phase_i,
    input logic       cpu_en_i,
    input logic       periph_en_i,
    input logic       rst_pin_n_i,
    input seq_state_e st_i,
    input logic       sel_i
);
    // R1
    phase_gap_chk: assert property (@(posedge clk_i) disable iff (por_i)
        bus_phase_i |=> !bus_phase_i);
    // R1
    en_align_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (cpu_en_i || periph_en_i) |-> bus_phase_i);
    // R3
    rst_quiet_chk: assert property (@(posedge clk_i) disable iff (por_i)
        !rst_pin_n_i |-> !(bus_phase_i || cpu_en_i || periph_en_i));
    // R4
    stop_quiet_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (st_i == ST_STOP || st_i == ST_RECOVER) |-> !(cpu_en_i || periph_en_i));
    // R6
    sel_hold_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (st_i == ST_RECOVER && $past(st_i) == ST_RECOVER) |-> $stable(sel_i));
    // R7
    wait_cpu_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (st_i == ST_WAIT) |-> !cpu_en_i);
    // R9
    ext_rst_chk: assert property (@(posedge clk_i) disable iff (por_i)
        ext_rst_i |=> (!rst_pin_n_i && !periph_en_i));
endmodule

bind busclk_sequencer busclk_seq_chk chk_i (
    .clk_i       (osc_clk_i),
    .por_i       (por_i),
    .ext_rst_i   (ext_rst_i),
    .bus_phase_i (bus_phase_o),
    .cpu_en_i    (cpu_en_o),
    .periph_en_i (periph_en_o),
    .rst_pin_n_i (rst_pin_n_o),
    .st_i        (r_q.st),
    .sel_i       (r_q.short_sel)
);

// File: tb/busclk_sequencer_tb_top.sv
`timescale 1ns/1ps
module busclk_sequencer_tb_top;
    localparam int LONG_N  = 4096;
    localparam int SHORT_N = 32;

    logic clk = 1'b0;
    logic por, stop_req, wait_req, wake_irq, wake_brk, ext_rst, short_dly;
    logic bus_phase, cpu_en, per_en, rst_n;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    busclk_sequencer dut_i (
        .osc_clk_i   (clk),
        .por_i       (por),
        .stop_req_i  (stop_req),
        .wait_req_i  (wait_req),
        .wake_irq_i  (wake_irq),
        .wake_brk_i  (wake_brk),
        .ext_rst_i   (ext_rst),
        .short_dly_i (short_dly),
        .bus_phase_o (bus_phase),
        .cpu_en_o    (cpu_en),
        .periph_en_o (per_en),
        .rst_pin_n_o (rst_n)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {28'd0, rst_n, bus_phase, cpu_en, per_en};
    endfunction

    // Waits for a phase-zero pulse; the caller is then in a phase-zero cycle.
    task automatic sync_phase0();
        for (int i = 0; i < 8 && !bus_phase; i++) tick();
    endtask

    task automatic t_powerup();
        check("R2 reset state", outs(), 0);
        por = 1'b0;
        tick(LONG_N - 1);
        check("R2 pin low last count cycle", outs(), 0);
        tick();
        check("R2 release rst/phase/cpu/per", outs(), 4'b1111);
    endtask

    task automatic t_phase();
        int bad = 0;
        int pulses = 0;
        for (int i = 1; i <= 16; i++) begin
            tick();
            if (bus_phase) pulses++;
            if (bus_phase != ((i % 4) == 0) || cpu_en != bus_phase) bad++;
        end
        check("R1 pulses in 16 cycles", pulses, 4);
        check("R1 pulse pattern errors", bad, 0);
    endtask

    task automatic t_wait();
        int bad = 0;
        sync_phase0();
        wait_req = 1'b1;
        tick(4);
        wait_req = 1'b0;
        check("R7 wait entry per only", outs(), 4'b1101);
        for (int i = 1; i <= 8; i++) begin
            tick();
            if (cpu_en || per_en != ((i % 4) == 0)) bad++;
        end
        check("R7 wait pattern errors", bad, 0);
        tick();
        wake_brk = 1'b1;
        tick();
        wake_brk = 1'b0;
        tick();
        check("R8 no cpu before boundary", cpu_en, 0);
        tick();
        check("R8 cpu back at boundary", outs(), 4'b1111);
    endtask

    task automatic t_stop(input logic sel, input int lim, input string rq);
        int bad = 0;
        sync_phase0();
        stop_req  = 1'b1;
        short_dly = sel;
        tick(4);
        stop_req  = 1'b0;
        short_dly = ~sel;
        for (int i = 0; i < 6; i++) begin
            if (bus_phase || cpu_en || per_en) bad++;
            tick();
        end
        check({rq, " quiet in stop"}, bad, 0);
        wake_irq = 1'b1;
        tick();
        wake_irq = 1'b0;
        tick(lim - 1);
        check({rq, " R6 still off last cycle"}, outs(), 4'b1000);
        tick();
        check({rq, " R6 enables return"}, outs(), 4'b1111);
        short_dly = 1'b0;
    endtask

    task automatic t_ext_reset();
        sync_phase0();
        stop_req  = 1'b1;
        short_dly = 1'b1;
        tick(4);
        stop_req = 1'b0;
        wake_irq = 1'b1;
        tick();
        wake_irq = 1'b0;
        tick(10);
        ext_rst = 1'b1;
        tick();
        ext_rst = 1'b0;
        check("R9 pin low after ext reset", outs(), 0);
        tick(LONG_N - 1);
        check("R9 still low at full count", outs(), 0);
        tick();
        check("R9 release after full count", outs(), 4'b1111);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        por = 1'b1; stop_req = 1'b0; wait_req = 1'b0; wake_irq = 1'b0;
        wake_brk = 1'b0; ext_rst = 1'b0; short_dly = 1'b0;
        tick(3);
        t_powerup();
        t_phase();
        t_wait();
        t_stop(1'b0, LONG_N, "R4");
        t_stop(1'b1, SHORT_N, "R5");
        t_ext_reset();
        t_phase();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule